// File: doc/BRIEF.md
# Rectangle Fill Engine

This block paints a solid, axis-aligned rectangle into an 8-bit-per-pixel frame buffer. A host programs a fill colour, a plane mask and an inclusive clip window through a small register port. It then writes two corner points, each as a y coordinate followed by an x coordinate. The x write of the second corner starts the operation on its own, and no separate start command exists.

While running, the engine visits the surviving pixels row by row, from top to bottom and from left to right, and issues one write per pixel on a simple memory port with a ready handshake. The port carries a linear address of `y * XRES + x`. Each fill latches its colour, mask and bounds when it launches. A status word shows that the engine is busy. A second status word carries a retry indication for a host that wrote a corner too early.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset the clip registers read 0 (x low, addr 4), 0 (y low, addr 5), XRES-1 (x high, addr 6) and YRES-1 (y high, addr 7), the status word (addr 8) and the draw-status word (addr 9) read 0, and no memory write is issued.
- R2: Corner y is written at addr 0 and corner x at addr 1, y before x. The first pair is the start corner. The x write of the second pair launches the fill, and the corner sequencer then expects a first corner again.
- R3: The end corner is exclusive: a fill covers columns x0..x1-1 and rows y0..y1-1, each pixel written exactly once, in row-major order with rising addresses, at address y*XRES+x.
- R4: Every pixel is clipped against the inclusive window [x low, x high] by [y low, y high]. Each axis is clipped independently.
- R5: A launch whose clipped area is empty (x1<=x0, y1<=y0, or entirely outside the window) issues no write, and status bit 28 stays low.
- R6: Status bit 28 reads 1 from the cycle after an accepted non-empty launch until the last pixel write is accepted, and reads 0 otherwise.
- R7: A corner write (addr 0 or 1) that arrives while busy is discarded and does not advance the sequencer. Until the fill ends, draw status then reads bits 31 and 29 set (0xA0000000). It reads 0 once busy is low.
- R8: Every pixel write carries the colour (addr 2) and plane mask (addr 3) that were present at launch. Later writes to those registers affect only later fills.
- R9: While a write is presented and mem_ready is low, mem_we, mem_addr, mem_wdata and mem_wmask hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_waddr | input | 4 | Register write address |
| host_wdata | input | 32 | Register write data |
| host_raddr | input | 4 | Register read address |
| host_rdata | output | 32 | Register read data (combinational) |
| mem_we | output | 1 | Pixel write request |
| mem_addr | output | ADDR_W (12) | Linear pixel address |
| mem_wdata | output | 8 | Pixel colour |
| mem_wmask | output | 8 | Per-bit write enable |
| mem_ready | input | 1 | Memory accepts the current write |

## Verification
The hardest condition to reach is a corner write that lands while a fill is still running. The write must be dropped without disturbing the half-filled corner sequencer, and the retry bits must stay up only while busy. The bench reaches it by launching a wide fill under random mem_ready stalls. It then writes both corner registers and the colour register mid-fill, and afterwards proves through a normal two-corner fill that the sequencer was untouched. Random windows and rectangles that straddle or miss the window cover the clipping edges.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
    parameter int COORD_W = 12;
    parameter int DATA_W  = 32;
    parameter int PIX_W   = 8;
    parameter int REG_AW  = 4;

    localparam int BUSY_BIT       = 28;
    localparam int DRAW_NEG_BIT   = 31;
    localparam int DRAW_RETRY_BIT = 29;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [PIX_W-1:0]   pix_t;

    typedef enum logic [REG_AW-1:0] {
        RA_CORNER_Y = 4'd0,
        RA_CORNER_X = 4'd1,
        RA_FG       = 4'd2,
        RA_PMASK    = 4'd3,
        RA_CLIP_XLO = 4'd4,
        RA_CLIP_YLO = 4'd5,
        RA_CLIP_XHI = 4'd6,
        RA_CLIP_YHI = 4'd7,
        RA_STATUS   = 4'd8,
        RA_DRAW     = 4'd9
    } reg_addr_e;

    typedef enum logic {CS_FIRST, CS_SECOND} corner_state_e;

    typedef struct packed {
        logic   empty;
        coord_t first;
        coord_t last;
    } span_t;

    typedef struct packed {
        coord_t x_first;
        coord_t x_last;
        coord_t y_first;
        coord_t y_last;
        pix_t   colour;
        pix_t   mask;
    } job_t;

    // Clip the half-open interval [a, b) against the inclusive window [lo, hi].
    function automatic span_t clip_span(coord_t a, coord_t b, coord_t lo, coord_t hi);
        span_t  s;
        coord_t e;
        s.first = (a > lo) ? a : lo;
        e       = b - coord_t'(1);
        s.last  = (e < hi) ? e : hi;
        s.empty = (b <= a) || (s.first > s.last);
        return s;
    endfunction
endpackage

// File: rtl/rfe_regs.sv
module rfe_regs
    import rfe_pkg::*;
#(
    parameter int XRES = 64,
    parameter int YRES = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_waddr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              busy,
    output pix_t              fg,
    output pix_t              pmask,
    output coord_t            clip_xlo,
    output coord_t            clip_ylo,
    output coord_t            clip_xhi,
    output coord_t            clip_yhi,
    output coord_t            cx0,
    output coord_t            cy0,
    output coord_t            cx1,
    output coord_t            cy1,
    output logic              launch,
    output logic              retry_q
);
    localparam coord_t XMAX_RST = coord_t'(XRES - 1);
    localparam coord_t YMAX_RST = coord_t'(YRES - 1);

    corner_state_e seq_q;
    coord_t        y_pend_q;
    logic          wr_y, wr_x, corner_wr;

    assign wr_y      = host_we && (reg_addr_e'(host_waddr) == RA_CORNER_Y);
    assign wr_x      = host_we && (reg_addr_e'(host_waddr) == RA_CORNER_X);
    assign corner_wr = wr_y || wr_x;
    assign launch    = wr_x && !busy && (seq_q == CS_SECOND);
    assign cx1       = host_wdata[COORD_W-1:0];
    assign cy1       = y_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fg       <= '0;
            pmask    <= '0;
            clip_xlo <= '0;
            clip_ylo <= '0;
            clip_xhi <= XMAX_RST;
            clip_yhi <= YMAX_RST;
        end else if (host_we) begin
            case (reg_addr_e'(host_waddr))
                RA_FG:       fg       <= host_wdata[PIX_W-1:0];
                RA_PMASK:    pmask    <= host_wdata[PIX_W-1:0];
                RA_CLIP_XLO: clip_xlo <= host_wdata[COORD_W-1:0];
                RA_CLIP_YLO: clip_ylo <= host_wdata[COORD_W-1:0];
                RA_CLIP_XHI: clip_xhi <= host_wdata[COORD_W-1:0];
                RA_CLIP_YHI: clip_yhi <= host_wdata[COORD_W-1:0];
                default: ;
            endcase
        end
    end

    // Corner sequencer: y then x, first corner then second; writes while busy are dropped.
    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q    <= CS_FIRST;
            y_pend_q <= '0;
            cx0      <= '0;
            cy0      <= '0;
        end else if (!busy) begin
            if (wr_y) y_pend_q <= host_wdata[COORD_W-1:0];
            if (wr_x) begin
                if (seq_q == CS_FIRST) begin
                    cx0   <= host_wdata[COORD_W-1:0];
                    cy0   <= y_pend_q;
                    seq_q <= CS_SECOND;
                end else begin
                    seq_q <= CS_FIRST;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !busy) retry_q <= 1'b0;
        else if (corner_wr) retry_q <= 1'b1;
    end
endmodule

// File: rtl/rfe_clip.sv
module rfe_clip
    import rfe_pkg::*;
(
    input  coord_t cx0,
    input  coord_t cy0,
    input  coord_t cx1,
    input  coord_t cy1,
    input  coord_t clip_xlo,
    input  coord_t clip_ylo,
    input  coord_t clip_xhi,
    input  coord_t clip_yhi,
    input  pix_t   fg,
    input  pix_t   pmask,
    output job_t   job,
    output logic   empty
);
    span_t xs, ys;

    always_comb begin
        xs = clip_span(cx0, cx1, clip_xlo, clip_xhi);
        ys = clip_span(cy0, cy1, clip_ylo, clip_yhi);
        job.x_first = xs.first;
        job.x_last  = xs.last;
        job.y_first = ys.first;
        job.y_last  = ys.last;
        job.colour  = fg;
        job.mask    = pmask;
        empty       = xs.empty || ys.empty;
    end
endmodule

// File: rtl/rfe_walker.sv
module rfe_walker
    import rfe_pkg::*;
#(
    parameter int XRES   = 64,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  job_t              job,
    input  logic              mem_ready,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output pix_t              mem_wdata,
    output pix_t              mem_wmask
);
    localparam bit XRES_POW2 = ((XRES & (XRES - 1)) == 0);
    localparam int XSHIFT    = $clog2(XRES);

    job_t   job_q;
    coord_t cur_x, cur_y;
    logic   running;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            job_q   <= '0;
            cur_x   <= '0;
            cur_y   <= '0;
        end else if (!running) begin
            if (start) begin
                job_q   <= job;
                cur_x   <= job.x_first;
                cur_y   <= job.y_first;
                running <= 1'b1;
            end
        end else if (mem_ready) begin
            if (cur_x == job_q.x_last) begin
                cur_x <= job_q.x_first;
                if (cur_y == job_q.y_last) running <= 1'b0;
                else cur_y <= cur_y + coord_t'(1);
            end else begin
                cur_x <= cur_x + coord_t'(1);
            end
        end
    end

    generate
        if (XRES_POW2) begin : g_shift_addr
            assign mem_addr = (ADDR_W'(cur_y) << XSHIFT) + ADDR_W'(cur_x);
        end else begin : g_mult_addr
            assign mem_addr = ADDR_W'(cur_y) * ADDR_W'(XRES) + ADDR_W'(cur_x);
        end
    endgenerate

    assign busy      = running;
    assign mem_we    = running;
    assign mem_wdata = job_q.colour;
    assign mem_wmask = job_q.mask;
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
    import rfe_pkg::*;
#(
    parameter int XRES = 64,
    parameter int YRES = 48,
    localparam int ADDR_W = $clog2(XRES * YRES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_waddr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [REG_AW-1:0] host_raddr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output pix_t              mem_wdata,
    output pix_t              mem_wmask,
    input  logic              mem_ready
);
    pix_t   fg, pmask;
    coord_t clip_xlo, clip_ylo, clip_xhi, clip_yhi;
    coord_t cx0, cy0, cx1, cy1;
    logic   launch, retry_q, busy, empty, retry_vis;
    job_t   job;

    rfe_regs #(.XRES(XRES), .YRES(YRES)) u_regs (
        .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .busy(busy), .fg(fg), .pmask(pmask),
        .clip_xlo(clip_xlo), .clip_ylo(clip_ylo), .clip_xhi(clip_xhi),
        .clip_yhi(clip_yhi), .cx0(cx0), .cy0(cy0), .cx1(cx1), .cy1(cy1),
        .launch(launch), .retry_q(retry_q)
    );

    rfe_clip u_clip (
        .cx0(cx0), .cy0(cy0), .cx1(cx1), .cy1(cy1),
        .clip_xlo(clip_xlo), .clip_ylo(clip_ylo), .clip_xhi(clip_xhi),
        .clip_yhi(clip_yhi), .fg(fg), .pmask(pmask), .job(job), .empty(empty)
    );

    rfe_walker #(.XRES(XRES), .ADDR_W(ADDR_W)) u_walker (
        .clk(clk), .rst(rst), .start(launch && !empty), .job(job),
        .mem_ready(mem_ready), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask)
    );

    assign retry_vis = retry_q && busy;

    always_comb begin
        host_rdata = '0;
        case (reg_addr_e'(host_raddr))
            RA_FG:       host_rdata = DATA_W'(fg);
            RA_PMASK:    host_rdata = DATA_W'(pmask);
            RA_CLIP_XLO: host_rdata = DATA_W'(clip_xlo);
            RA_CLIP_YLO: host_rdata = DATA_W'(clip_ylo);
            RA_CLIP_XHI: host_rdata = DATA_W'(clip_xhi);
            RA_CLIP_YHI: host_rdata = DATA_W'(clip_yhi);
            RA_STATUS:   host_rdata[BUSY_BIT] = busy;
            RA_DRAW: begin
                host_rdata[DRAW_NEG_BIT]   = retry_vis;
                host_rdata[DRAW_RETRY_BIT] = retry_vis;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker
    import rfe_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [REG_AW-1:0] host_waddr,
    input logic              busy,
    input logic              retry_vis,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input pix_t              mem_wdata,
    input pix_t              mem_wmask,
    input logic              mem_ready
);
    logic corner_wr;
    assign corner_wr = host_we && (host_waddr == 4'd0 || host_waddr == 4'd1);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_we && !busy)); // R1

    AST_ROW_MAJOR: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_ready) |=> (!mem_we || mem_addr > $past(mem_addr))); // R3

    AST_DISCARD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (busy && corner_wr) |=> (!busy || retry_vis)); // R7

    AST_COLOUR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_wdata == $past(mem_wdata) && mem_wmask == $past(mem_wmask))); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_wmask))); // R9
endmodule

bind rect_fill_engine rfe_checker #(.ADDR_W(ADDR_W)) u_rfe_checker (
    .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
    .busy(busy), .retry_vis(retry_vis), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_ready(mem_ready)
);

// File: tb/test_rect_fill_engine.sv
`timescale 1ns/1ps
module test_rect_fill_engine;
    localparam int XRES = 64;
    localparam int YRES = 48;
    localparam int AW   = $clog2(XRES * YRES);
    localparam int CAP  = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_we = 1'b0;
    logic [3:0]    host_waddr = '0;
    logic [31:0]   host_wdata = '0;
    logic [3:0]    host_raddr = '0;
    logic [31:0]   host_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_wmask;
    logic          mem_ready = 1'b1;

    int checks = 0, failures = 0;
    bit stall_en = 0, finished = 0;
    int cap_n = 0;
    int cap_addr[CAP];
    int cap_data[CAP];
    int cap_mask[CAP];
    int exp_addr[CAP];
    int exp_n;
    int m_xlo = 0, m_ylo = 0, m_xhi = XRES - 1, m_yhi = YRES - 1;
    int m_fg = 0, m_pm = 0, l_fg, l_pm;

    rect_fill_engine #(.XRES(XRES), .YRES(YRES)) i_rect_fill_engine (
        .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wmask(mem_wmask), .mem_ready(mem_ready)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        mem_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
        #1;
        if (mem_we && mem_ready && cap_n < CAP) begin
            cap_addr[cap_n] = int'(mem_addr);
            cap_data[cap_n] = int'(mem_wdata);
            cap_mask[cap_n] = int'(mem_wmask);
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = 4'(a); host_wdata = 32'(d);
        @(negedge clk);
        host_we = 1'b0;
        if (a == 2) m_fg = d & 255;
        if (a == 3) m_pm = d & 255;
        if (a == 4) m_xlo = d;
        if (a == 5) m_ylo = d;
        if (a == 6) m_xhi = d;
        if (a == 7) m_yhi = d;
    endtask

    task automatic rd(input int a, output int v);
        host_raddr = 4'(a);
        #1 v = int'(host_rdata);
    endtask

    function automatic int imax(int a, int b); return a > b ? a : b; endfunction
    function automatic int imin(int a, int b); return a < b ? a : b; endfunction

    task automatic build_expected(input int x0, input int y0, input int x1, input int y1);
        exp_n = 0;
        for (int y = imax(y0, m_ylo); y <= imin(y1 - 1, m_yhi); y++)
            for (int x = imax(x0, m_xlo); x <= imin(x1 - 1, m_xhi); x++) begin
                exp_addr[exp_n] = y * XRES + x;
                exp_n++;
            end
        l_fg = m_fg; l_pm = m_pm;
    endtask

    // R2: y then x for each corner; the second x write launches
    task automatic launch(input int x0, input int y0, input int x1, input int y1);
        build_expected(x0, y0, x1, y1);
        cap_n = 0;
        wr(0, y0); wr(1, x0); wr(0, y1); wr(1, x1);
    endtask

    task automatic wait_idle();
        int v;
        for (int i = 0; i < 20000; i++) begin
            rd(8, v);
            if (v == 0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic compare(input string req);
        int bad;
        bad = 0;
        chk(cap_n == exp_n, req, "pixel count", cap_n, exp_n);
        for (int i = 0; i < imin(cap_n, exp_n); i++)
            if (cap_addr[i] != exp_addr[i] || cap_data[i] != l_fg || cap_mask[i] != l_pm) begin
                if (bad == 0) begin
                    chk(cap_addr[i] == exp_addr[i], req, "pixel address", cap_addr[i], exp_addr[i]);
                    chk(cap_data[i] == l_fg, "R8", "pixel colour", cap_data[i], l_fg);
                    chk(cap_mask[i] == l_pm, "R8", "pixel mask", cap_mask[i], l_pm);
                end
                bad++;
            end
        chk(bad == 0, req, "mismatching pixels", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        rd(4, v); chk(v == 0, "R1", "clip x low", v, 0);
        rd(5, v); chk(v == 0, "R1", "clip y low", v, 0);
        rd(6, v); chk(v == XRES - 1, "R1", "clip x high", v, XRES - 1);
        rd(7, v); chk(v == YRES - 1, "R1", "clip y high", v, YRES - 1);
        rd(8, v); chk(v == 0, "R1", "status", v, 0);
        rd(9, v); chk(v == 0, "R1", "draw status", v, 0);
        chk(mem_we == 1'b0, "R1", "mem_we idle", int'(mem_we), 0);

        // R3: small exclusive-end fill; R6 busy right after launch
        wr(2, 8'hC3); wr(3, 8'hFF);
        launch(3, 2, 6, 5);
        rd(8, v); chk(v == 32'h1000_0000, "R6", "busy after launch", v, 32'h1000_0000);
        wait_idle();
        compare("R3");
        rd(8, v); chk(v == 0, "R6", "idle after fill", v, 0);

        // R2: second fill back to back; sequencer restarted at first corner
        launch(10, 0, 11, 3);
        wait_idle();
        compare("R2");

        // R4: partial clip on all four edges
        wr(4, 5); wr(5, 4); wr(6, 20); wr(7, 9);
        rd(6, v); chk(v == 20, "R4", "clip x high readback", v, 20);
        launch(0, 0, 30, 15);
        wait_idle();
        compare("R4");

        // R5: outside window, and degenerate corners
        launch(30, 0, 40, 5);
        rd(8, v); chk(v == 0, "R5", "no busy for empty fill", v, 0);
        wait_idle();
        chk(cap_n == 0, "R5", "writes for outside rect", cap_n, 0);
        launch(8, 6, 8, 9);
        wait_idle();
        chk(cap_n == 0, "R5", "writes for zero width", cap_n, 0);
        launch(8, 6, 12, 6);
        wait_idle();
        chk(cap_n == 0, "R5", "writes for zero height", cap_n, 0);

        // R7/R8/R9: corner writes and colour change mid-fill, with stalls
        wr(4, 0); wr(5, 0); wr(6, XRES - 1); wr(7, YRES - 1);
        stall_en = 1;
        wr(2, 8'h5A); wr(3, 8'h0F);
        launch(0, 0, 40, 10);
        wr(0, 3);
        rd(9, v); chk(v == 32'hA000_0000, "R7", "retry after dropped y write", v, 32'hA000_0000);
        wr(1, 7);
        wr(2, 8'h11);
        rd(9, v); chk(v == 32'hA000_0000, "R7", "retry after dropped x write", v, 32'hA000_0000);
        wait_idle();
        compare("R9");
        rd(9, v); chk(v == 0, "R7", "retry cleared when idle", v, 0);
        launch(2, 20, 5, 22);
        wait_idle();
        compare("R7");

        // R4 random: windows and rectangles, some straddling or missing
        for (int n = 0; n < 24; n++) begin
            int a, b, x0, y0;
            a = $urandom_range(0, 30); b = $urandom_range(a, XRES - 1);
            wr(4, a); wr(6, b);
            a = $urandom_range(0, 20); b = $urandom_range(a, YRES - 1);
            wr(5, a); wr(7, b);
            wr(2, $urandom_range(0, 255)); wr(3, $urandom_range(0, 255));
            x0 = $urandom_range(0, XRES + 4); y0 = $urandom_range(0, YRES + 4);
            launch(x0, y0, x0 + $urandom_range(0, 24), y0 + $urandom_range(0, 16));
            wait_idle();
            compare("R4");
        end
        stall_en = 0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule